// File: doc/BRIEF.md
# Tagged Sequential Cache Prefetcher

This block sits beside a small direct-mapped cache. It watches the demand accesses and sends out prefetch requests for the blocks that come right after the one being accessed. It keeps its own copy of the cache tags, indexed by set. Each line in that copy also has one marker bit, which records that the line arrived through a prefetch rather than through a demand fill.

Two events start a prefetch burst:
- a demand access that the cache reports as a miss;
- the first demand hit to a line whose marker bit is still set. That hit also clears the bit, so later hits to the same line stay quiet.

A burst covers block B+1 up to block B+DEGREE. Two kinds of candidate are skipped:
- a candidate whose tag is already present in the array;
- a candidate that would pass the top of the address space.

The candidates that remain enter a small request queue, in increasing address order. The queue hands them out one at a time through a valid/ready pair. A candidate that finds no free slot is dropped.

Top module: `tagged_seq_prefetcher`

## Requirements
- R1: After reset, pf_valid is low, every line is invalid and every marker bit is clear.
- R2: An access with acc_valid=1 and acc_hit=0 to block B queues targets B+1 .. B+DEGREE in increasing order. The first of them appears on pf_blk with pf_valid=1 one cycle after the access.
- R3: An access with acc_hit=1 whose set holds a valid line with a matching tag and a set marker bit triggers the same burst as R2. The same access clears the marker bit, so the next hit to that line triggers nothing.
- R4: A hit to a line whose marker bit is clear causes no request. This covers a line from a demand fill (fill_pf=0) and a line whose bit was already cleared.
- R5: A target whose block is already present in the tag array (valid, and stored tag equal) is not queued.
- R6: A target greater than 2^ADDR_W-1 is not queued. Addresses never wrap.
- R7: The queue holds up to Q_DEPTH requests in FIFO order. Free space for an access cycle is Q_DEPTH minus the occupancy, plus one when a request is popped in that cycle. Targets beyond the free space are dropped, and the lower addresses keep priority.
- R8: While pf_valid=1 and pf_ready=0, pf_valid stays high and pf_blk stays unchanged.
- R9: The set is acc_blk[SET_W-1:0] and the tag is the remaining upper bits. A fill writes the line's tag, marks it valid and loads the marker bit from fill_pf. When a fill and a marker-clearing hit reach the same set in one cycle, the fill wins. Presence checks in a cycle use the tags from before that cycle's fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_blk | input | ADDR_W | Block address of the demand access |
| acc_hit | input | 1 | Cache lookup result for the access (1 = hit) |
| fill_valid | input | 1 | A line fill completes this cycle |
| fill_blk | input | ADDR_W | Block address of the fill |
| fill_pf | input | 1 | Fill was caused by a prefetch |
| pf_valid | output | 1 | Prefetch request available |
| pf_blk | output | ADDR_W | Block address of the prefetch request |
| pf_ready | input | 1 | Consumer accepts the request this cycle |

## Verification
The bench builds the block with ADDR_W=8, SET_W=2, DEGREE=2 and Q_DEPTH=3. Each of these values brings a different case within reach:
- An 8-bit block address makes the top of the address space easy to hit, with bursts that are cut short at 0xFF.
- Four sets make collisions between fills, accesses and candidate lookups frequent.
- Two targets per burst against a three-deep queue make partial drops, and pops in the same cycle as a push, common.

Random traffic that mixes hits, misses, demand fills and prefetch fills is compared against a reference model kept in the bench.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int unsigned WIDE_W = 64;
  typedef logic [WIDE_W-1:0] wide_blk_t;

  // block address k positions ahead, computed wide so overflow is visible
  function automatic wide_blk_t blk_ahead(wide_blk_t base, int unsigned k);
    return base + wide_blk_t'(k);
  endfunction

  // true when a wide sum no longer fits in aw bits
  function automatic logic past_top(wide_blk_t sum, int unsigned aw);
    return (sum >> aw) != '0;
  endfunction

  // position inside a ring of the given depth
  function automatic int unsigned ring_idx(int unsigned pos, int unsigned depth);
    return pos % depth;
  endfunction
endpackage

// File: rtl/pfx_tag_array.sv
module pfx_tag_array #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SET_W  = 4,
  parameter int unsigned NPORT  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_valid,
  input  logic [ADDR_W-1:0]           fill_blk,
  input  logic                        fill_pf,
  input  logic                        clr_valid,
  input  logic [SET_W-1:0]            clr_set,
  input  logic [NPORT-1:0][ADDR_W-1:0] look_blk,
  output logic [NPORT-1:0]            look_present,
  output logic                        look0_pf
);
  localparam int unsigned SETS  = 1 << SET_W;
  localparam int unsigned TAG_W = ADDR_W - SET_W;

  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  mark_q;
  logic [TAG_W-1:0] tag_q [SETS];

  logic [SET_W-1:0] fill_set;
  assign fill_set = fill_blk[SET_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      mark_q <= '0;
      for (int s = 0; s < int'(SETS); s++) tag_q[s] <= '0;
    end else begin
      for (int s = 0; s < int'(SETS); s++) begin
        if (fill_valid && fill_set == SET_W'(s)) begin
          vld_q[s]  <= 1'b1;
          mark_q[s] <= fill_pf;
          tag_q[s]  <= fill_blk[ADDR_W-1:SET_W];
        end else if (clr_valid && clr_set == SET_W'(s)) begin
          mark_q[s] <= 1'b0;
        end
      end
    end
  end

  for (genvar p = 0; p < int'(NPORT); p++) begin : g_look
    logic [SET_W-1:0] idx;
    assign idx = look_blk[p][SET_W-1:0];
    assign look_present[p] = vld_q[idx] && (tag_q[idx] == look_blk[p][ADDR_W-1:SET_W]);
  end
  assign look0_pf = mark_q[look_blk[0][SET_W-1:0]];

  // a marker cleared by a hit stays cleared unless a fill hit the same set
  assert_mark_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !(fill_valid && fill_set == clr_set)) |=> !mark_q[$past(clr_set)]);

  // a fill leaves the line valid with its marker taken from the fill kind
  assert_fill_loads_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (vld_q[$past(fill_set)] && mark_q[$past(fill_set)] == $past(fill_pf)));
endmodule

// File: rtl/pfx_target_gen.sv
module pfx_target_gen
  import pfx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEGREE = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         trig,
  input  logic [ADDR_W-1:0]            acc_blk,
  input  logic [DEGREE-1:0]            cand_present,
  output logic [DEGREE-1:0][ADDR_W-1:0] cand_blk,
  output logic [DEGREE-1:0]            cand_ok
);
  for (genvar k = 0; k < int'(DEGREE); k++) begin : g_cand
    wide_blk_t sum;
    assign sum         = blk_ahead(wide_blk_t'(acc_blk), k + 1);
    assign cand_blk[k] = sum[ADDR_W-1:0];
    assign cand_ok[k]  = trig && !past_top(sum, ADDR_W) && !cand_present[k];

    // an accepted target always lies above the accessed block
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cand_ok[k] |-> (cand_blk[k] > acc_blk));
  end
endmodule

// File: rtl/pfx_req_queue.sv
module pfx_req_queue
  import pfx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned NPUSH  = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPUSH-1:0]             in_ok,
  input  logic [NPUSH-1:0][ADDR_W-1:0] in_blk,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic [ADDR_W-1:0]            out_blk,
  output logic [$clog2(NPUSH+1)-1:0]   n_pushed
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned NP_W  = $clog2(NPUSH + 1);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop;
  logic [ADDR_W-1:0] push_blk [NPUSH];
  int unsigned       push_n;

  assign out_valid = cnt_q != '0;
  assign out_blk   = mem[rd_q];
  assign pop       = out_valid && out_ready;
  assign n_pushed  = NP_W'(push_n);

  // compact the accepted targets, lowest address first, into free slots
  always_comb begin
    int unsigned free;
    free   = DEPTH - int'(cnt_q) + (pop ? 1 : 0);
    push_n = 0;
    for (int k = 0; k < int'(NPUSH); k++) push_blk[k] = '0;
    for (int k = 0; k < int'(NPUSH); k++) begin
      if (in_ok[k] && push_n < free) begin
        push_blk[push_n] = in_blk[k];
        push_n = push_n + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else begin
      if (pop) rd_q <= PTR_W'(ring_idx(int'(rd_q) + 1, DEPTH));
      cnt_q <= CNT_W'(int'(cnt_q) - (pop ? 1 : 0) + int'(push_n));
      for (int j = 0; j < int'(NPUSH); j++) begin
        if (j < int'(push_n))
          mem[ring_idx(int'(rd_q) + int'(cnt_q) + j, DEPTH)] <= push_blk[j];
      end
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_hold_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_blk)));
endmodule

// File: rtl/tagged_seq_prefetcher.sv
module tagged_seq_prefetcher #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SET_W   = 4,
  parameter int unsigned DEGREE  = 1,
  parameter int unsigned Q_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_blk,
  input  logic              acc_hit,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_blk,
  input  logic              fill_pf,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_blk,
  input  logic              pf_ready
);
  localparam int unsigned NPORT = DEGREE + 1;
  localparam int unsigned NP_W  = $clog2(DEGREE + 1);

  logic [NPORT-1:0][ADDR_W-1:0]  look_blk;
  logic [NPORT-1:0]              look_present;
  logic                          acc_mark;
  logic                          tagged_hit;
  logic                          miss_evt;
  logic                          trig;
  logic [DEGREE-1:0][ADDR_W-1:0] cand_blk;
  logic [DEGREE-1:0]             cand_ok;
  logic [NP_W-1:0]               n_pushed;

  // named trigger events
  assign tagged_hit = acc_valid && acc_hit && look_present[0] && acc_mark;
  assign miss_evt   = acc_valid && !acc_hit;
  assign trig       = miss_evt || tagged_hit;

  assign look_blk[0] = acc_blk;
  for (genvar k = 0; k < int'(DEGREE); k++) begin : g_port
    assign look_blk[k+1] = cand_blk[k];
  end

  pfx_tag_array #(.ADDR_W(ADDR_W), .SET_W(SET_W), .NPORT(NPORT)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_pf(fill_pf),
    .clr_valid(tagged_hit), .clr_set(acc_blk[SET_W-1:0]),
    .look_blk(look_blk), .look_present(look_present), .look0_pf(acc_mark)
  );

  pfx_target_gen #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_gen (
    .clk(clk), .rst_n(rst_n), .trig(trig), .acc_blk(acc_blk),
    .cand_present(look_present[NPORT-1:1]),
    .cand_blk(cand_blk), .cand_ok(cand_ok)
  );

  pfx_req_queue #(.ADDR_W(ADDR_W), .DEPTH(Q_DEPTH), .NPUSH(DEGREE)) u_q (
    .clk(clk), .rst_n(rst_n), .in_ok(cand_ok), .in_blk(cand_blk),
    .out_ready(pf_ready), .out_valid(pf_valid), .out_blk(pf_blk),
    .n_pushed(n_pushed)
  );

  // requests enter the queue only on a miss or a first hit to a marked line
  assert_push_only_on_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (n_pushed != '0) |-> trig);

  // a queued request always comes from an access in the cycle before
  assert_request_follows_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pf_valid)) |-> $past(trig));
endmodule

// File: tb/test_tagged_seq_prefetcher.sv
`timescale 1ns/1ps
module test_tagged_seq_prefetcher;
  localparam int AW = 8, SW = 2, DEG = 2, QD = 3;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_hit = 0, fill_valid = 0, fill_pf = 0, pf_ready = 0;
  logic [AW-1:0] acc_blk = '0, fill_blk = '0;
  logic pf_valid;
  logic [AW-1:0] pf_blk;

  always #2 clk = ~clk;

  tagged_seq_prefetcher #(.ADDR_W(AW), .SET_W(SW), .DEGREE(DEG), .Q_DEPTH(QD)) i_tagged_seq_prefetcher (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_blk(acc_blk), .acc_hit(acc_hit),
    .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_pf(fill_pf),
    .pf_valid(pf_valid), .pf_blk(pf_blk), .pf_ready(pf_ready));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  bit            m_vld [4];
  bit            m_mark[4];
  logic [AW-SW-1:0] m_tag[4];
  logic [AW-1:0] mq[$];

  function automatic bit m_present(int b);
    return m_vld[b % 4] && (m_tag[b % 4] == AW'(b) >> SW);
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin m_vld[s] = 0; m_mark[s] = 0; m_tag[s] = '0; end
    mq.delete();
  endtask

  // next state from the inputs driven in this cycle
  task automatic model_step();
    int s;
    bit mark_hit, trig;
    if (pf_ready && mq.size() > 0) void'(mq.pop_front());
    mark_hit = 0;
    if (acc_valid) begin
      s = int'(acc_blk) % 4;
      mark_hit = acc_hit && m_present(int'(acc_blk)) && m_mark[s];
      trig = !acc_hit || mark_hit;
      if (trig) for (int k = 1; k <= DEG; k++) begin
        int t = int'(acc_blk) + k;
        if (t <= 255 && !m_present(t) && mq.size() < QD) mq.push_back(AW'(t));
      end
      if (mark_hit) m_mark[s] = 0;
    end
    if (fill_valid) begin
      s = int'(fill_blk) % 4;
      m_vld[s] = 1; m_mark[s] = fill_pf; m_tag[s] = fill_blk[AW-1:SW];
    end
  endtask

  task automatic check(string req);
    bit ev = mq.size() != 0;
    checks++;
    if (pf_valid !== ev || (ev && pf_blk !== mq[0])) begin
      fails++;
      $display("FAIL %s: actual valid=%0b blk=%h expected valid=%0b blk=%h",
               req, pf_valid, pf_blk, ev, ev ? mq[0] : '0);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_hit = 0; fill_valid = 0; fill_pf = 0; pf_ready = 0;
  endtask

  task automatic cyc(string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(req);
    idle();
  endtask

  task automatic acc(logic [AW-1:0] b, logic h, logic rdy, string req);
    acc_valid = 1; acc_blk = b; acc_hit = h; pf_ready = rdy; cyc(req);
  endtask

  task automatic fill(logic [AW-1:0] b, logic p, string req);
    fill_valid = 1; fill_blk = b; fill_pf = p; cyc(req);
  endtask

  task automatic drain(string req);
    while (mq.size() > 0 || pf_valid) begin pf_ready = 1; cyc(req); end
  endtask

  function automatic logic [AW-1:0] pick_blk();
    return ($urandom_range(0, 3) == 0) ? AW'($urandom_range(248, 255)) : AW'($urandom_range(0, 31));
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 reset state");
    acc(8'h00, 1, 0, "R1 hit after reset gives nothing");
    // R2 miss burst, held without ready (R8)
    acc(8'h10, 0, 0, "R2 miss burst first target");
    cyc("R8 hold without ready");
    cyc("R8 hold without ready");
    pf_ready = 1; cyc("R2 second target after pop");
    drain("R2 drain");
    // R5 present target skipped
    fill(8'h21, 0, "R5 demand fill");
    acc(8'h20, 0, 0, "R5 present target skipped");
    drain("R5 drain");
    // R3 tagged hit, then quiet
    fill(8'h31, 1, "R3 prefetch fill");
    acc(8'h31, 1, 0, "R3 first hit to marked line");
    drain("R3 drain");
    acc(8'h31, 1, 0, "R3 second hit quiet");
    // R4 demand-filled line hit
    fill(8'h41, 0, "R4 demand fill");
    acc(8'h41, 1, 0, "R4 unmarked hit quiet");
    fill(8'h45, 1, "R4 marked then overwritten");
    fill(8'h45, 0, "R4 demand fill clears mark");
    acc(8'h45, 1, 0, "R4 hit after demand refill quiet");
    // R6 top of address space
    acc(8'hFE, 0, 0, "R6 burst cut at top");
    drain("R6 drain");
    acc(8'hFF, 0, 0, "R6 no target past top");
    // R7 overflow with partial drop
    acc(8'h50, 0, 0, "R7 fill two slots");
    acc(8'h60, 0, 0, "R7 one slot left");
    acc(8'h70, 0, 0, "R7 full drops all");
    drain("R7 fifo order");
    acc(8'h80, 0, 0, "R7 refill");
    acc(8'h88, 0, 0, "R7 refill");
    acc(8'h90, 0, 1, "R7 pop frees a slot");
    drain("R7 drain");
    // R9 fill and marker clear on one set in one cycle
    fill(8'h35, 1, "R9 prefetch fill");
    acc_valid = 1; acc_blk = 8'h35; acc_hit = 1;
    fill_valid = 1; fill_blk = 8'h39; fill_pf = 1;
    cyc("R9 fill wins same set");
    drain("R9 drain");
    acc(8'h39, 1, 0, "R9 mark kept by fill");
    drain("R9 drain");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 1) == 1) begin
        acc_valid = 1; acc_blk = pick_blk();
        acc_hit = ($urandom_range(0, 9) != 0) ? logic'(m_present(int'(acc_blk))) : logic'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 9) < 3) begin
        fill_valid = 1; fill_blk = pick_blk(); fill_pf = logic'($urandom_range(0, 1));
      end
      pf_ready = logic'($urandom_range(0, 1));
      cyc("R2/R3/R5/R6/R7/R9 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule